// File: doc/BRIEF.md
# Edge-Triggered Interrupt Status Controller

This block collects event lines from ten peripheral sources: a system-supply-low monitor, a power button, a watchdog timeout, an ADC conversion-done flag, four ADC threshold comparators, and a real-time-clock tick and alarm. Every line first passes through a synchronizer into the block's clock domain. An edge detector then catches the kind of transition that source cares about, and the event is held in a sticky bit of a 16-bit status word.

Software reads the status word and acknowledges events by writing ones to it. A 16-bit mask register decides which held events drive the registered interrupt line. A separate combinational summary reports whether any event is held at all, whatever the mask says.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status word reads 0x0000, the mask reads 0xFFFF (every source masked), and `irq_out` is 0.
- R2: The sources at `src_in` indices 9, 7, 6, 1 and 0 set a status bit on a 0-to-1 change only. Their status bits are 15, 11, 8, 3 and 2.
- R3: The source at `src_in` index 8 sets status bit 12 on both a 0-to-1 and a 1-to-0 change.
- R4: The comparator sources at `src_in` indices 2..5 set status bits 4..7. Comparator n (n = 0..3, at index n+2) triggers on a rising change when `cmp_rise[n]` is 1 and on a falling change when it is 0.
- R5: A source change that the clock first samples at edge k shows in `stat_rdata` after edge k+2 and not before (two synchronizer stages plus the latch).
- R6: A write with `bus_we`=1 and `bus_sel`=0 clears every status bit where `bus_wdata` is 1. Bits where the data is 0 keep their value.
- R7: When a trigger edge and a clear of the same bit fall in the same cycle, the bit ends up 1.
- R8: Bits 14, 13, 10, 9, 1 and 0 of `stat_rdata` always read 0.
- R9: A write with `bus_we`=1 and `bus_sel`=1 loads `bus_wdata` into the mask, which reads back on `mask_rdata`. A mask bit of 1 blocks that status bit.
- R10: `irq_out` is a register that equals the OR of (status AND NOT mask) as it stood one cycle earlier.
- R11: `irq_summary` is 1 whenever any status bit is 1, regardless of the mask.
- R12: A status bit stays set after its source returns to its old level, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 10 | Raw source event lines |
| cmp_rise | input | 4 | Per-comparator trigger direction (1 rising, 0 falling) |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | Write target: 0 status (clear), 1 mask |
| bus_wdata | input | 16 | Write data |
| stat_rdata | output | 16 | Latched status word |
| mask_rdata | output | 16 | Current mask |
| irq_summary | output | 1 | OR of all status bits |
| irq_out | output | 1 | Registered masked interrupt |

## Verification
The bench sweeps every source through both start levels and both comparator directions. It checks each case against a polarity rule computed in the bench, so a source wired to the wrong bit or given the wrong sensitivity sets the wrong bit or none at all. It samples the status word one cycle before the expected latch and again at the latch, which catches a synchronizer that has a stage too few or too many. It also aims a clear at the exact cycle a new edge lands, where a clear-priority design would lose the event. Partial clears, sticky behaviour after the source falls back, and masked sources that light the summary but not the interrupt line round out the cases.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 10;
  localparam int WORD_W = 16;
  localparam int NCMP   = 4;

  typedef enum logic [1:0] {EDGE_RISE, EDGE_BOTH, EDGE_CFG} edge_mode_t;

  // status bit position of each source index
  function automatic int src_pos(input int idx);
    case (idx)
      0: return 2;
      1: return 3;
      6: return 8;
      7: return 11;
      8: return 12;
      9: return 15;
      default: return idx + 2;   // comparators 2..5 -> bits 4..7
    endcase
  endfunction

  function automatic edge_mode_t src_mode(input int idx);
    if (idx == 8) return EDGE_BOTH;
    if (idx >= 2 && idx <= 5) return EDGE_CFG;
    return EDGE_RISE;
  endfunction

  function automatic logic [WORD_W-1:0] valid_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[src_pos(i)] = 1'b1;
    return m;
  endfunction

  function automatic logic edge_hit(input edge_mode_t mode, input logic cur,
                                    input logic prev, input logic dir_rise);
    case (mode)
      EDGE_RISE: return cur & ~prev;
      EDGE_BOTH: return cur ^ prev;
      default:   return dir_rise ? (cur & ~prev) : (~cur & prev);
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_edge_cell.sv
module irq_edge_cell
  import irq_pkg::*;
#(
  parameter edge_mode_t MODE = EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic dir_rise,
  input  logic clr,
  output logic hit,
  output logic stat
);
  logic prev_q;

  assign hit = edge_hit(MODE, sync_in, prev_q, dir_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat   <= 1'b0;
    end else begin
      prev_q <= sync_in;
      if (hit)      stat <= 1'b1;   // set beats clear
      else if (clr) stat <= 1'b0;
    end
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !stat);
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !clr) |=> stat);
  p_only_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat && !hit) |=> !stat);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic [NCMP-1:0]   cmp_rise,
  input  logic              bus_we,
  input  logic              bus_sel,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] stat_rdata,
  output logic [WORD_W-1:0] mask_rdata,
  output logic              irq_summary,
  output logic              irq_out
);
  localparam logic [WORD_W-1:0] VALID = valid_mask();

  logic [NSRC-1:0]   src_sync;
  logic [NSRC-1:0]   src_hit;
  logic [WORD_W-1:0] stat_w;
  logic [WORD_W-1:0] mask_q;
  logic              clr_wr;
  logic              mask_wr;
  logic              irq_q;

  assign clr_wr  = bus_we & ~bus_sel;
  assign mask_wr = bus_we & bus_sel;

  irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_in), .q(src_sync)
  );

  for (genvar b = 0; b < WORD_W; b++) begin : g_fill
    if (!VALID[b]) begin : g_zero
      assign stat_w[b] = 1'b0;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int         POS  = src_pos(i);
    localparam edge_mode_t MODE = src_mode(i);
    logic dir;
    if (MODE == EDGE_CFG) begin : g_dir
      assign dir = cmp_rise[i-2];
    end else begin : g_nodir
      assign dir = 1'b1;
    end
    irq_edge_cell #(.MODE(MODE)) u_cell (
      .clk(clk), .rst_n(rst_n), .sync_in(src_sync[i]), .dir_rise(dir),
      .clr(clr_wr & bus_wdata[POS]), .hit(src_hit[i]), .stat(stat_w[POS])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= bus_wdata;
      irq_q <= |(stat_w & ~mask_q);
    end
  end

  assign stat_rdata  = stat_w;
  assign mask_rdata  = mask_q;
  assign irq_summary = |stat_w;
  assign irq_out     = irq_q;

  p_irq_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|(stat_rdata & ~mask_rdata))));
  p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_rdata == $past(bus_wdata)));
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata & ~VALID) == '0);
  p_hit_any_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_hit) |=> irq_summary);
endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  src_in = '0;
  logic [3:0]  cmp_rise = '0;
  logic        bus_we = 1'b0;
  logic        bus_sel = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] stat_rdata, mask_rdata;
  logic        irq_summary, irq_out;

  int checks = 0;
  int errors = 0;

  irq_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .cmp_rise(cmp_rise),
    .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .stat_rdata(stat_rdata), .mask_rdata(mask_rdata),
    .irq_summary(irq_summary), .irq_out(irq_out)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic int bitpos(input int idx);
    int t [10] = '{2, 3, 4, 5, 6, 7, 8, 11, 12, 15};
    return t[idx];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
    tick(1);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    chk("R1 status", stat_rdata, 16'h0000);
    chk("R1 mask", mask_rdata, 16'hFFFF);
    chk("R1 irq", {15'd0, irq_out}, 16'h0000);
    rst_n = 1'b1;
    tick(2);

    // R2 R3 R4 R5 sweep: every source, both directions, both start levels
    for (int i = 0; i < 10; i++) begin
      for (int dir = 0; dir < 2; dir++) begin
        for (int lvl = 0; lvl < 2; lvl++) begin
          logic rising, fire;
          cmp_rise = {4{dir[0]}};
          src_in = '0;
          src_in[i] = lvl[0];
          tick(4);
          wr(1'b0, 16'hFFFF);
          src_in[i] = ~lvl[0];
          rising = (lvl == 0);
          if (i == 8)                fire = 1'b1;
          else if (i >= 2 && i <= 5) fire = dir[0] ? rising : !rising;
          else                       fire = rising;
          tick(2);
          chk("R5 early", stat_rdata, 16'h0000);
          tick(1);
          chk(i == 8 ? "R3" : ((i >= 2 && i <= 5) ? "R4" : "R2"),
              stat_rdata, fire ? (16'h1 << bitpos(i)) : 16'h0000);
        end
      end
    end
    src_in = '0; tick(4); wr(1'b0, 16'hFFFF);
    chk("R1 irq masked", {15'd0, irq_out}, 16'h0000);

    // R8: all sources rise together
    cmp_rise = 4'hF;
    src_in = 10'h3FF;
    tick(3);
    chk("R8 layout", stat_rdata, 16'h99FC);
    chk("R11 summary", {15'd0, irq_summary}, 16'h0001);
    // R12: sources drop (only index 8 re-fires, already set)
    src_in = '0;
    tick(4);
    chk("R12 sticky", stat_rdata, 16'h99FC);
    // R6: partial clear
    wr(1'b0, 16'h0804);
    chk("R6 partial", stat_rdata, 16'h91F8);
    wr(1'b0, 16'h0000);
    chk("R6 zero write", stat_rdata, 16'h91F8);
    wr(1'b0, 16'hFFFF);
    chk("R6 clear all", stat_rdata, 16'h0000);

    // R7: clear lands in the latch cycle
    src_in[7] = 1'b1;
    tick(1); tick(1);
    bus_we = 1'b1; bus_sel = 1'b0; bus_wdata = 16'h0800;
    tick(1);
    bus_we = 1'b0;
    chk("R7 set wins", stat_rdata, 16'h0800);
    wr(1'b0, 16'h0800);
    chk("R7 later clear", stat_rdata, 16'h0000);
    src_in = '0; tick(4);

    // R9 R10 R11: unmask only bit 2
    wr(1'b1, 16'hFFFB);
    chk("R9 mask read", mask_rdata, 16'hFFFB);
    src_in[1] = 1'b1;                       // bit 3, masked
    tick(4);
    chk("R11 masked summary", {15'd0, irq_summary}, 16'h0001);
    chk("R10 masked irq", {15'd0, irq_out}, 16'h0000);
    src_in[0] = 1'b1;                       // bit 2, unmasked
    tick(3);
    chk("R10 before lag", {15'd0, irq_out}, 16'h0000);
    tick(1);
    chk("R10 after lag", {15'd0, irq_out}, 16'h0001);
    wr(1'b0, 16'h0004);
    chk("R10 status cleared", stat_rdata, 16'h0008);
    tick(1);
    chk("R10 irq drops", {15'd0, irq_out}, 16'h0000);
    wr(1'b1, 16'h0000);
    tick(1);
    chk("R9 unmask all", {15'd0, irq_out}, 16'h0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule